// File: doc/BRIEF.md
# Sawtooth PWM Gate with Latched Overcurrent Fault

This block makes the chopping signal for the low-side switches of a brushless motor bridge and guards that signal with a latched overcurrent fault. A free-running up-counter forms a digital sawtooth whose length is set at run time. While a speed setpoint lies below the present sawtooth value, the low-side gate is on. Raising the setpoint narrows the pulse, so the setpoint sets the motor speed.

A digital overcurrent flag from an external comparator is sampled on every clock. Any sample with the flag high sets a fault latch, and the latch turns the gate off. The latch does not re-arm as soon as the current falls. It clears only at the start of a new sawtooth ramp or on a rising edge of the (synchronised) enable input, and only if the flag is low at that moment. The fault then cycles no faster than the chop rate. While the brake is applied, the overcurrent flag is ignored. An option stops the oscillator, so that the enable input alone chops the gate and alone re-arms the latch.

Top module: `sawtooth_pwm_guard`

## Requirements
- R1: With the oscillator running, `ramp_o` counts up by one per clock from 0 to `period_i`-1 and then returns to 0. A `period_i` of 0 is treated as 1, which holds the ramp at 0.
- R2: With the oscillator running, `gate_o` is high exactly when the synchronised enable is high, the fault is clear and `trip_i` < `ramp_o`. A `trip_i` of 0 gives the largest duty, (P-1)/P. A `trip_i` of P or more keeps the gate low.
- R3: When `ocp_i` is high and `brake_i` is low at a clock edge, `fault_o` is high after that edge and `gate_o` is low while `fault_o` is high.
- R4: Without a clear event, a set fault stays set.
- R5: A ramp start clears the fault, provided `ocp_i` is low in that cycle. The ramp-start cycle is the cycle in which `ramp_o` is 0 after a wrap.
- R6: `enable_i` passes through a two-flop synchroniser. The clock after the synchronised copy rises is a clear event. With `ocp_i` low, the fault is low two clock edges after the synchroniser captured the high level.
- R7: When a set and a clear event fall in the same cycle, the fault is set.
- R8: While `brake_i` is high, `ocp_i` has no effect. A clear fault stays clear, and a set fault still clears on a clear event.
- R9: With `osc_off_i` high, `ramp_o` is held at 0 and gives no ramp starts. `gate_o` is then high exactly when the synchronised enable is high and no fault is set.
- R10: After reset, `ramp_o` is 0, `fault_o` is low and `gate_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | W | Sawtooth length in clocks |
| trip_i | input | W | Speed setpoint compared against the ramp |
| osc_off_i | input | 1 | Stops the oscillator; the enable input alone chops |
| enable_i | input | 1 | Asynchronous enable / chop input |
| brake_i | input | 1 | Brake active; masks the overcurrent input |
| ocp_i | input | 1 | Overcurrent comparator flag |
| gate_o | output | 1 | Low-side PWM gate |
| fault_o | output | 1 | Latched overcurrent fault |
| ramp_o | output | W | Present sawtooth value |

## Verification
A wrong count shows on `ramp_o` in the same cycle. A wrong gate decision shows on `gate_o` in that cycle as well. A fault latch that misses a set, or that clears without a clear event, differs on `fault_o` one clock after the cause. A fault that clears on the wrong event typically stays wrong until the next ramp start or enable edge. An enable synchroniser with the wrong depth moves both the gate and the clear by one clock, which shows at once.

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic         osc_off_i,
  output logic [W-1:0] ramp_o,
  output logic         start_o
);
  function automatic logic [W-1:0] last_index(input logic [W-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic [W-1:0] cnt_q;
  logic         start_q;
  logic [W-1:0] last_w;
  logic         at_end_w;

  assign last_w   = last_index(period_i);
  assign at_end_w = (cnt_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else if (osc_off_i) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else if (at_end_w) begin
      cnt_q   <= '0;
      start_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      start_q <= 1'b0;
    end
  end

  assign ramp_o  = cnt_q;
  assign start_o = start_q;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_off_i && at_end_w) |=> (cnt_q == '0 && start_q));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_off_i && !at_end_w) |=> (cnt_q == $past(cnt_q) + 1'b1 && !start_q));
  assert_osc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_i |=> (cnt_q == '0 && !start_q));
endmodule

// File: rtl/enable_edge.sv
module enable_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic en_s_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign en_s_o = sync_q[SYNC_STAGES-1];
  assign rise_o = en_s_o & ~prev_q;

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ocp_i,
  input  logic brake_i,
  input  logic clear_i,
  output logic fault_o
);
  logic set_w;
  logic fault_q;

  assign set_w = ocp_i & ~brake_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_q <= 1'b0;
    else if (set_w)   fault_q <= 1'b1;
    else if (clear_i) fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_i && !brake_i) |=> fault_q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clear_i) |=> fault_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_i && !brake_i && clear_i) |=> fault_q);
  assert_brake_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_i && !fault_q) |=> !fault_q);
endmodule

// File: rtl/sawtooth_pwm_guard.sv
module sawtooth_pwm_guard #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] trip_i,
  input  logic         osc_off_i,
  input  logic         enable_i,
  input  logic         brake_i,
  input  logic         ocp_i,
  output logic         gate_o,
  output logic         fault_o,
  output logic [W-1:0] ramp_o
);
  function automatic logic trip_below(input logic [W-1:0] trip, input logic [W-1:0] ramp);
    return trip < ramp;
  endfunction

  logic         ramp_start_w;
  logic         en_sync_w;
  logic         en_rise_w;
  logic         clear_evt_w;
  logic         pwm_on_w;
  logic         fault_w;
  logic [W-1:0] ramp_w;

  ramp_gen #(.W(W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_i  (period_i),
    .osc_off_i (osc_off_i),
    .ramp_o    (ramp_w),
    .start_o   (ramp_start_w)
  );

  enable_edge #(.SYNC_STAGES(SYNC_STAGES)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (enable_i),
    .en_s_o (en_sync_w),
    .rise_o (en_rise_w)
  );

  assign clear_evt_w = ramp_start_w | en_rise_w;

  fault_latch u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .ocp_i   (ocp_i),
    .brake_i (brake_i),
    .clear_i (clear_evt_w),
    .fault_o (fault_w)
  );

  assign pwm_on_w = osc_off_i | trip_below(trip_i, ramp_w);
  assign gate_o   = en_sync_w & pwm_on_w & ~fault_w;
  assign fault_o  = fault_w;
  assign ramp_o   = ramp_w;

  assert_gate_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_w |-> !gate_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_w && ramp_start_w && !ocp_i) |=> !fault_w);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_w && en_rise_w && !ocp_i) |=> !fault_w);
  assert_no_osc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off_i && $past(osc_off_i)) |-> !ramp_start_w);
endmodule

// File: tb/sawtooth_pwm_guard_test.sv
module sawtooth_pwm_guard_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] period_i = 8'd10;
  logic [W-1:0] trip_i = '0;
  logic         osc_off_i = 1'b0;
  logic         enable_i = 1'b0;
  logic         brake_i = 1'b0;
  logic         ocp_i = 1'b0;
  logic         gate_o;
  logic         fault_o;
  logic [W-1:0] ramp_o;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  sawtooth_pwm_guard #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .trip_i(trip_i),
    .osc_off_i(osc_off_i), .enable_i(enable_i), .brake_i(brake_i),
    .ocp_i(ocp_i), .gate_o(gate_o), .fault_o(fault_o), .ramp_o(ramp_o)
  );

  // reference state, built from the requirements
  int    m_cnt;
  bit    m_start, m_s1, m_s2, m_prev, m_fault;
  string fault_tag;

  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic bit exp_gate(input bit ens, input bit off, input int trip,
                                  input int ramp, input bit flt);
    if (!ens || flt) return 1'b0;
    if (off) return 1'b1;
    return (trip < ramp);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_start = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_fault = 0;
    fault_tag = "R10";
  endtask

  task automatic model_step();
    bit rise, clr, set_n;
    rise  = m_s2 & ~m_prev;
    clr   = m_start | rise;
    set_n = ocp_i & ~brake_i;
    if (set_n && clr)        fault_tag = "R7";
    else if (set_n)          fault_tag = "R3";
    else if (brake_i && ocp_i) fault_tag = "R8";
    else if (clr && rise)    fault_tag = "R6";
    else if (clr)            fault_tag = "R5";
    else                     fault_tag = "R4";
    if (set_n)    m_fault = 1;
    else if (clr) m_fault = 0;
    if (osc_off_i) begin
      m_cnt = 0; m_start = 0;
    end else if (m_cnt >= eff_period(int'(period_i)) - 1) begin
      m_cnt = 0; m_start = 1;
    end else begin
      m_cnt = m_cnt + 1; m_start = 0;
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = enable_i;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(osc_off_i ? "R9" : "R1", int'(ramp_o), m_cnt, "ramp");
    check(osc_off_i ? "R9" : "R2", int'(gate_o),
          int'(exp_gate(m_s2, osc_off_i, int'(trip_i), m_cnt, m_fault)), "gate");
    check(fault_tag, int'(fault_o), int'(m_fault), "fault");
  endtask

  // one clock: check at negedge, apply caller's inputs already set, advance
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5A3C));
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", int'(ramp_o), 0, "ramp after reset");
    check("R10", int'(fault_o), 0, "fault after reset");
    check("R10", int'(gate_o), 0, "gate after reset");
    rst_n = 1'b1;

    // R1/R2: ramp with enable high, several setpoints and periods
    enable_i = 1'b1;
    trip_i = 8'd3;
    repeat (40) tick();
    trip_i = 8'd0;                 // R2 max duty
    repeat (25) tick();
    trip_i = 8'd10;                // R2 zero duty (trip == period)
    repeat (25) tick();
    period_i = 8'd0;               // R1 period 0 behaves as 1
    repeat (6) tick();
    period_i = 8'd1;
    repeat (4) tick();
    period_i = 8'd255; trip_i = 8'd200;
    repeat (300) tick();

    // R3/R4/R5: pulse overcurrent, hold until ramp start
    period_i = 8'd16; trip_i = 8'd4;
    repeat (20) tick();
    ocp_i = 1'b1; tick();
    ocp_i = 1'b0; repeat (40) tick();

    // R7: overcurrent held across a ramp start keeps the fault
    ocp_i = 1'b1; repeat (40) tick();
    ocp_i = 1'b0; repeat (20) tick();

    // R8: brake masks overcurrent
    brake_i = 1'b1; ocp_i = 1'b1; repeat (20) tick();
    brake_i = 1'b0; ocp_i = 1'b0; repeat (5) tick();

    // R9/R6: oscillator off, enable chops and re-arms
    osc_off_i = 1'b1;
    repeat (5) tick();
    ocp_i = 1'b1; tick(); ocp_i = 1'b0;
    repeat (30) tick();            // no ramp start: fault must hold (R4)
    enable_i = 1'b0; repeat (4) tick();
    enable_i = 1'b1; repeat (6) tick();   // R6 clear
    ocp_i = 1'b1; enable_i = 1'b0; repeat (4) tick();
    enable_i = 1'b1; repeat (6) tick();   // R7 edge while ocp high
    ocp_i = 1'b0; repeat (4) tick();
    osc_off_i = 1'b0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) period_i = W'($urandom % 40);
      if (($urandom % 16) == 0) trip_i = W'($urandom % 45);
      if (($urandom % 400) == 0) osc_off_i = ~osc_off_i;
      if (($urandom % 12) == 0) enable_i = ~enable_i;
      brake_i = (($urandom % 20) == 0);
      ocp_i   = (($urandom % 25) == 0);
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule